// File: doc/BRIEF.md
# Audio Master Clock Source Selector

This block picks the master clock handed to downstream converters in an audio receiver. It has three candidate sources: a free-running clock at half the crystal rate, a recovered clock at 256 times the sample rate, and that recovered clock halved to 128 times the sample rate. The recovered clocks are built from a tick that the clock-recovery loop raises twice per 256fs period. The source is chosen from the lock state, a force-free-run control bit, a two-bit mode code and the double-rate flag. A master/slave strap can park the output low.

Every change of source goes through a handover. The old source is gated off while it is low, the block waits through a synchronisation delay, and the new source is let through only when it is low. Because of this, no pulse is ever cut short. The block also registers the lock, error and double-rate status flags that belong with this choice. A separate output carries the free-running clock at all times.

Top module: `audio_mclk_select`

## Requirements
- R1: `free_mclk` inverts on every clock cycle after reset, so its period is two clock cycles.
- R2: While `pll_locked` is 0 and the block is not in slave mode, `sel_mclk` carries the free-running clock.
- R3: While `pll_locked` is 1 and `force_free` is 1, `sel_mclk` carries the free-running clock.
- R4: While locked with `force_free` at 0, `lock_mode` codes 2'b00 and 2'b11 select the recovered 256fs clock at both rates. Its period is two `rec_tick` periods.
- R5: While locked with `force_free` at 0, `lock_mode` 2'b01 selects recovered 256fs when `dbl_rate` is 0, and recovered 128fs (twice the 256fs period) when `dbl_rate` is 1.
- R6: While locked with `force_free` at 0, `lock_mode` 2'b10 selects recovered 256fs when `dbl_rate` is 0, and the free-running clock when `dbl_rate` is 1.
- R7: While `slave_mode` is 1, `sel_mclk` settles low and stays low.
- R8: `dbl_out` is 1 one cycle after the inputs show lock, double rate and no free-run case (R2, R3 or the R6 double-rate case). Otherwise it is 0.
- R9: `err_out` is 1 one cycle after `pll_locked` is 0 or `parity_err` is 1. Otherwise it is 0.
- R10: `lock_n` is the inverse of `pll_locked`, delayed by one cycle.
- R11: Across any source change, every high pulse on `sel_mclk` is a full half-period of its source (1, `rec_tick` period, or twice that). The new source appears within 40 cycles.
- R12: In reset, `sel_mclk`, `free_mclk` and `dbl_out` are 0, and `lock_n` and `err_out` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1 = slave, selected clock held low |
| pll_locked | input | 1 | Clock recovery locked to the stream |
| dbl_rate | input | 1 | Stream is at 64 to 96 kHz |
| parity_err | input | 1 | Parity error reported by the decoder |
| rec_tick | input | 1 | One-cycle tick at 512fs from clock recovery |
| force_free | input | 1 | Force the free-running clock while locked |
| lock_mode | input | 2 | Source table code used while locked |
| free_mclk | output | 1 | Free-running master clock |
| sel_mclk | output | 1 | Selected master clock |
| lock_n | output | 1 | Lock indication, active low |
| err_out | output | 1 | Error indication |
| dbl_out | output | 1 | Double-rate indication |

## Verification
A wrong decode shows up at `sel_mclk` as the wrong rising-edge count in a 64-cycle window. Each source has its own count, so this is visible within one window after the handover settles. A handover state that gates at the wrong moment leaves a high pulse on `sel_mclk` whose length matches no source half-period, and this is seen on the very next falling edge. Status flag faults appear one cycle after the input change.

// File: rtl/mclk_sel_pkg.sv
// Shared types for the master clock selector.
// Source codes double as bit indices into the source vector.
package mclk_sel_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FREE = 2'd1,
        SRC_R256 = 2'd2,
        SRC_R128 = 2'd3
    } mclk_src_e;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        SW_RUN,
        SW_DRAIN,
        SW_SYNC,
        SW_ARM
    } sw_state_e;
endpackage

// File: rtl/mclk_src_gen.sv
// Builds every candidate clock as a register in the clk domain.
// Assumes rec_tick is a one-cycle pulse no more often than every other cycle.
// Bit k of src_vec carries the source whose code is k; bit 0 is a constant low.
module mclk_src_gen
    import mclk_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_tick,
    output logic [NUM_SRC-1:0] src_vec
);
    logic free_q;
    logic r256_q;
    logic r128_q;

    // free-running clock: halve the crystal-rate clock
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= 1'b0;
        else        free_q <= ~free_q;
    end

    // recovered 256fs: invert on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)        r256_q <= 1'b0;
        else if (rec_tick) r256_q <= ~r256_q;
    end

    // recovered 128fs: invert when 256fs falls
    always_ff @(posedge clk) begin
        if (!rst_n)                  r128_q <= 1'b0;
        else if (rec_tick && r256_q) r128_q <= ~r128_q;
    end

    assign src_vec[SRC_NONE] = 1'b0;
    assign src_vec[SRC_FREE] = free_q;
    assign src_vec[SRC_R256] = r256_q;
    assign src_vec[SRC_R128] = r128_q;

    assert_free_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (free_q != $past(free_q)));

    assert_half_rate_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r128_q != $past(r128_q)) |-> ($past(r256_q) && !r256_q));
endmodule

// File: rtl/mclk_src_decode.sv
// Chooses the requested source from lock, rate, strap and control bits.
// It also registers the status flags that go with that choice.
// Assumes all inputs are already synchronous to clk.
module mclk_src_decode
    import mclk_sel_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              pll_locked,
    input  logic              dbl_rate,
    input  logic              parity_err,
    input  logic              force_free,
    input  logic [MODE_W-1:0] lock_mode,
    output mclk_src_e         req_src,
    output logic              lock_n,
    output logic              err_o,
    output logic              dbl_o
);
    localparam logic [MODE_W-1:0] MODE_HALF = MODE_W'(1);
    localparam logic [MODE_W-1:0] MODE_FREE = MODE_W'(2);

    logic free_case;

    // free-run case: unlocked, forced, or double rate under the free-at-double code
    always_comb begin
        free_case = !pll_locked || force_free ||
                    (lock_mode == MODE_FREE && dbl_rate);
    end

    // source request: slave parks the output, otherwise follow the table
    always_comb begin
        if (slave_mode)                               req_src = SRC_NONE;
        else if (free_case)                           req_src = SRC_FREE;
        else if (lock_mode == MODE_HALF && dbl_rate)  req_src = SRC_R128;
        else                                          req_src = SRC_R256;
    end

    // status flags, one register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_n <= 1'b1;
            err_o  <= 1'b1;
            dbl_o  <= 1'b0;
        end else begin
            lock_n <= !pll_locked;
            err_o  <= !pll_locked || parity_err;
            dbl_o  <= pll_locked && dbl_rate && !free_case;
        end
    end

    assert_dbl_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_o |-> $past(pll_locked && dbl_rate && !force_free));

    assert_err_when_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pll_locked)) |-> err_o);

    assert_lock_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lock_n == !$past(pll_locked)));
endmodule

// File: rtl/mclk_glitchless_switch.sv
// Hands the output over from one source to another without short pulses.
// Sequence: wait for the current source to be low and gate it off,
// wait SYNC_STAGES cycles (the synchroniser delay), then wait for the new
// source to be low and open its gate. The output is registered.
// Assumes each source holds every level for at least one cycle.
module mclk_glitchless_switch
    import mclk_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vec,
    input  mclk_src_e          req_src,
    output logic               mclk_o
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    sw_state_e        state;
    mclk_src_e        cur_src;
    mclk_src_e        nxt_src;
    logic             gate_on;
    logic [CNT_W-1:0] sync_cnt;
    logic             cur_level;

    assign cur_level = src_vec[cur_src];

    // handover sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SW_RUN;
            cur_src  <= SRC_NONE;
            nxt_src  <= SRC_NONE;
            gate_on  <= 1'b1;
            sync_cnt <= '0;
        end else begin
            case (state)
                SW_RUN: begin
                    if (req_src != cur_src) begin
                        nxt_src <= req_src;
                        state   <= SW_DRAIN;
                    end
                end
                SW_DRAIN: begin
                    if (!cur_level) begin
                        gate_on  <= 1'b0;
                        sync_cnt <= '0;
                        state    <= SW_SYNC;
                    end
                end
                SW_SYNC: begin
                    sync_cnt <= sync_cnt + 1'b1;
                    if (sync_cnt == CNT_W'(SYNC_STAGES - 1)) begin
                        cur_src <= nxt_src;
                        state   <= SW_ARM;
                    end
                end
                default: begin
                    if (!cur_level) begin
                        gate_on <= 1'b1;
                        state   <= SW_RUN;
                    end
                end
            endcase
        end
    end

    // registered output: gated copy of the current source
    always_ff @(posedge clk) begin
        if (!rst_n) mclk_o <= 1'b0;
        else        mclk_o <= gate_on && cur_level;
    end

    assert_gate_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && gate_on != $past(gate_on)) |-> !$past(cur_level));

    assert_source_swaps_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cur_src != $past(cur_src)) |-> (!gate_on && !$past(gate_on)));

    assert_parked_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src == SRC_NONE) |=> !mclk_o);
endmodule

// File: rtl/audio_mclk_select.sv
// Top of the master clock selector: candidate sources, source decode,
// glitch-free handover and status flags.
// Assumes one crystal-rate clock and a recovered-clock tick synchronous to it.
module audio_mclk_select
    import mclk_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MODE_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              pll_locked,
    input  logic              dbl_rate,
    input  logic              parity_err,
    input  logic              rec_tick,
    input  logic              force_free,
    input  logic [MODE_W-1:0] lock_mode,
    output logic              free_mclk,
    output logic              sel_mclk,
    output logic              lock_n,
    output logic              err_out,
    output logic              dbl_out
);
    logic [NUM_SRC-1:0] src_vec;
    mclk_src_e          req_src;

    mclk_src_gen u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_tick (rec_tick),
        .src_vec  (src_vec)
    );

    mclk_src_decode #(.MODE_W(MODE_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .pll_locked (pll_locked),
        .dbl_rate   (dbl_rate),
        .parity_err (parity_err),
        .force_free (force_free),
        .lock_mode  (lock_mode),
        .req_src    (req_src),
        .lock_n     (lock_n),
        .err_o      (err_out),
        .dbl_o      (dbl_out)
    );

    mclk_glitchless_switch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_vec (src_vec),
        .req_src (req_src),
        .mclk_o  (sel_mclk)
    );

    assign free_mclk = src_vec[SRC_FREE];

    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sel_mclk && !dbl_out && lock_n && err_out));
endmodule

// File: tb/audio_mclk_select_tb.sv
module audio_mclk_select_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_mode = 1'b0;
    logic       pll_locked = 1'b0;
    logic       dbl_rate = 1'b0;
    logic       parity_err = 1'b0;
    logic       rec_tick = 1'b0;
    logic       force_free = 1'b0;
    logic [1:0] lock_mode = 2'b00;
    logic       free_mclk, sel_mclk, lock_n, err_out, dbl_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit busy = 1'b0;
    int bad_pulses = 0;
    int pulses = 0;

    typedef struct {
        string tag;
        int    rises;
        bit    lock_n;
        bit    err;
        bit    dbl;
    } exp_t;
    exp_t exp_q[$];

    // rec_tick period 4 cycles: 256fs period 8, 128fs period 16, free period 2
    localparam int WIN = 64;

    always #2.5 clk = ~clk;

    audio_mclk_select u_dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .pll_locked(pll_locked),
        .dbl_rate(dbl_rate), .parity_err(parity_err), .rec_tick(rec_tick),
        .force_free(force_free), .lock_mode(lock_mode), .free_mclk(free_mclk),
        .sel_mclk(sel_mclk), .lock_n(lock_n), .err_out(err_out), .dbl_out(dbl_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // recovered-clock tick stimulus
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            rec_tick = (n % 4 == 0);
            n++;
        end
    end

    // pulse-width monitor for R11: every high pulse must be 1, 4 or 8 cycles
    initial begin
        int run = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) run = 0;
            else if (sel_mclk) run++;
            else if (run != 0) begin
                pulses++;
                if (run != 1 && run != 4 && run != 8) begin
                    bad_pulses++;
                    $display("FAIL R11 truncated pulse: actual=%0d expected=1/4/8", run);
                end
                run = 0;
            end
        end
    end

    // scoreboard monitor: pop, let the handover settle, then measure
    initial begin
        forever begin
            exp_t e;
            int rs, fr;
            bit p, pf;
            wait (exp_q.size() > 0);
            busy = 1'b1;
            e = exp_q.pop_front();
            repeat (40) @(negedge clk);
            rs = 0; fr = 0; p = sel_mclk; pf = free_mclk;
            for (int i = 0; i < WIN; i++) begin
                @(negedge clk);
                if (sel_mclk && !p) rs++;
                if (free_mclk && !pf) fr++;
                p = sel_mclk; pf = free_mclk;
            end
            chk(rs == e.rises, e.tag, "sel_mclk rises", rs, e.rises);
            chk(fr == WIN / 2, "R1", "free_mclk rises", fr, WIN / 2);
            chk(lock_n == e.lock_n, "R10", {e.tag, " lock_n"}, lock_n, e.lock_n);
            chk(err_out == e.err, "R9", {e.tag, " err_out"}, err_out, e.err);
            chk(dbl_out == e.dbl, "R8", {e.tag, " dbl_out"}, dbl_out, e.dbl);
            busy = 1'b0;
        end
    end

    task automatic apply(input string tag, input bit sl, input bit lk, input bit db,
                         input bit pe, input bit ff, input logic [1:0] md,
                         input int rises, input bit edbl);
        exp_t e;
        @(negedge clk);
        slave_mode = sl; pll_locked = lk; dbl_rate = db;
        parity_err = pe; force_free = ff; lock_mode = md;
        e.tag = tag; e.rises = rises; e.lock_n = !lk;
        e.err = !lk || pe; e.dbl = edbl;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        wait (!busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!sel_mclk && !free_mclk, "R12", "clocks in reset", sel_mclk, 0);
        chk(lock_n && err_out && !dbl_out, "R12", "flags in reset",
            {lock_n, err_out, dbl_out}, 3'b110);
        @(negedge clk);
        rst_n = 1'b1;
        //      tag   sl lk db pe ff mode   rises dbl
        apply("R2",  0, 0, 0, 0, 0, 2'b00, 32, 0);
        apply("R3",  0, 1, 1, 0, 1, 2'b00, 32, 0);
        apply("R4",  0, 1, 0, 0, 0, 2'b00,  8, 0);
        apply("R4",  0, 1, 1, 0, 0, 2'b00,  8, 1);
        apply("R4",  0, 1, 1, 0, 0, 2'b11,  8, 1);
        apply("R5",  0, 1, 0, 0, 0, 2'b01,  8, 0);
        apply("R5",  0, 1, 1, 0, 0, 2'b01,  4, 1);
        apply("R6",  0, 1, 0, 0, 0, 2'b10,  8, 0);
        apply("R6",  0, 1, 1, 0, 0, 2'b10, 32, 0);
        apply("R9",  0, 1, 0, 1, 0, 2'b00,  8, 0);
        apply("R7",  1, 1, 1, 0, 0, 2'b01,  0, 1);
        apply("R11", 0, 1, 1, 0, 0, 2'b01,  4, 1);
        apply("R2",  0, 0, 1, 0, 0, 2'b01, 32, 0);
        apply("R11", 0, 1, 0, 0, 0, 2'b10,  8, 0);
        chk(bad_pulses == 0, "R11", "truncated pulses", bad_pulses, 0);
        chk(pulses > 100, "R11", "pulses observed", pulses, 101);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule